// File: doc/BRIEF.md
# Fault-Gated Pin Output Enable

This block decides, for every pin of a timer's pin bank, whether the pin's output buffer is driven. Each pin carries a direction bit and a protection-select bit. Pins whose protection-select bit is clear are driven whenever their direction bit calls for an output. Pins whose protection-select bit is set are also gated by an active-low fault input and by a single global arm bit. A low level on the fault input turns these protected pins off through a purely combinational path, so no clock edge is needed and a stopped clock still cannot keep a protected pin driving.

The global arm bit is held in a two-state machine. The states are `ST_DISARMED`, where protected pins stay off, and `ST_ARMED`, where they follow their direction bits while the fault input is high. There are three transitions. `ARM` moves from `ST_DISARMED` to `ST_ARMED` on a software write of 1, but only while the synchronized fault level is high. `TRIP` moves from `ST_ARMED` to `ST_DISARMED` when the synchronized fault level is low. `DISARM` moves from `ST_ARMED` to `ST_DISARMED` on a software write of 0. When the fault clears, the machine does not return to `ST_ARMED` by itself. Software reads the synchronized fault level, waits until it is high, and then writes the arm bit again.

A chain of synchronizer flops produces the readable fault level. A one-cycle event pulse marks each falling edge of that level and can feed an interrupt controller.

Top module: `fault_oe_gate`

## Requirements
- R1: A pin whose `dis_sel_i` bit is 0 has `oe_o` equal to its `dir_i` bit. The fault input and the arm state have no effect on it.
- R2: A pin whose `dis_sel_i` bit is 1 has `oe_o` = 1 only when `fault_n_i` = 1, `arm_o` = 1 and its `dir_i` bit is 1. In every other case it has `oe_o` = 0.
- R3: While `fault_n_i` is low, every pin whose `dis_sel_i` bit is 1 has `oe_o` = 0 in the same instant. This holds even for a low pulse that falls between two clock edges.
- R4: After reset, the machine is in `ST_DISARMED` (`arm_o` = 0), `fault_lvl_o` = 1 and `fault_evt_o` = 0.
- R5: A cycle with `arm_wr_i` = 1 and `arm_wdata_i` = 1, taken while `fault_lvl_o` = 1, sets `arm_o` after that clock edge. A cycle with `arm_wr_i` = 1 and `arm_wdata_i` = 0 clears `arm_o` after that clock edge.
- R6: A low `fault_lvl_o` clears `arm_o` on the next clock edge. After the fault input returns high, `arm_o` stays 0 until software writes 1.
- R7: A set write in a cycle where `fault_lvl_o` is low has no effect, and `arm_o` stays 0. The hardware clear wins.
- R8: `fault_lvl_o` is `fault_n_i` delayed by `SYNC_STAGES` clock edges.
- R9: `fault_evt_o` is 1 for exactly the first cycle in which `fault_lvl_o` reads 0. A rising edge of `fault_lvl_o` gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fault_n_i | input | 1 | Active-low fault input, asynchronous |
| dir_i | input | NUM_PINS | Per-pin direction, 1 = output |
| dis_sel_i | input | NUM_PINS | Per-pin protection select, 1 = gated by fault and arm |
| arm_wr_i | input | 1 | Write strobe for the global arm bit |
| arm_wdata_i | input | 1 | Data written to the arm bit |
| oe_o | output | NUM_PINS | Per-pin output-buffer enable |
| arm_o | output | 1 | Global arm bit readback |
| fault_lvl_o | output | 1 | Synchronized fault level, for software polling |
| fault_evt_o | output | 1 | One-cycle pulse on a falling edge of the synchronized level |

## Verification
The bench builds the block with `NUM_PINS` = 8 and `SYNC_STAGES` = 2. Eight pins are enough to mix protected and unprotected pins, and driven and undriven pins, in a single vector, so each pin pattern checks all four combinations at once. With two sync stages the timing can be counted cycle by cycle. A check can therefore land in the exact cycle where the level drops, the pulse fires and the arm bit clears. The same timing lets a set write be placed in the window where it collides with an active fault. A sub-cycle fault pulse shows that the combinational shutdown acts while the synchronized path never sees the pulse.

// File: rtl/fog_pkg.sv
package fog_pkg;

    typedef enum logic {
        ST_DISARMED = 1'b0,
        ST_ARMED    = 1'b1
    } arm_state_e;

endpackage

// File: rtl/fog_fault_sync.sv
module fog_fault_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fault_n_i,
    output logic lvl_o,
    output logic fall_o
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;
    logic          lvl_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= fault_n_i;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[LAST-1:0], fault_n_i};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= 1'b1;
        else        lvl_q <= chain_q[LAST];
    end

    assign lvl_o  = chain_q[LAST];
    assign fall_o = lvl_q & ~chain_q[LAST];

    // R9
    evt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);

endmodule

// File: rtl/fog_arm_fsm.sv
module fog_arm_fsm
    import fog_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    input  logic wr_i,
    input  logic wdata_i,
    output logic arm_o
);
    arm_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_DISARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_DISARMED: if (wr_i && wdata_i && lvl_i) state_d = ST_ARMED;   // ARM
            ST_ARMED: begin
                if (!lvl_i)                  state_d = ST_DISARMED;          // TRIP
                else if (wr_i && !wdata_i)   state_d = ST_DISARMED;          // DISARM
            end
            default: state_d = ST_DISARMED;
        endcase
    end

    always_comb begin
        arm_o = (state_q == ST_ARMED);
    end

    // R6
    trip_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lvl_i |=> !arm_o);
    // R5
    set_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arm_o) |-> $past(wr_i && wdata_i));
    // R5
    sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !wdata_i) |=> !arm_o);

endmodule

// File: rtl/fog_oe_gate.sv
module fog_oe_gate #(
    parameter int NUM_PINS = 32
) (
    input  logic                fault_n_i,
    input  logic                arm_i,
    input  logic [NUM_PINS-1:0] dir_i,
    input  logic [NUM_PINS-1:0] dis_sel_i,
    output logic [NUM_PINS-1:0] oe_o
);
    logic allow_protected;

    assign allow_protected = fault_n_i & arm_i;

    generate
        for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
            assign oe_o[p] = dir_i[p] & (~dis_sel_i[p] | allow_protected);
        end
    endgenerate

endmodule

// File: rtl/fault_oe_gate.sv
module fault_oe_gate #(
    parameter int NUM_PINS    = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fault_n_i,
    input  logic [NUM_PINS-1:0] dir_i,
    input  logic [NUM_PINS-1:0] dis_sel_i,
    input  logic                arm_wr_i,
    input  logic                arm_wdata_i,
    output logic [NUM_PINS-1:0] oe_o,
    output logic                arm_o,
    output logic                fault_lvl_o,
    output logic                fault_evt_o
);
    logic lvl_w;
    logic fall_w;
    logic arm_w;

    fog_fault_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .fault_n_i (fault_n_i),
        .lvl_o     (lvl_w),
        .fall_o    (fall_w)
    );

    fog_arm_fsm fsm_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl_i   (lvl_w),
        .wr_i    (arm_wr_i),
        .wdata_i (arm_wdata_i),
        .arm_o   (arm_w)
    );

    fog_oe_gate #(.NUM_PINS(NUM_PINS)) gate_i (
        .fault_n_i (fault_n_i),
        .arm_i     (arm_w),
        .dir_i     (dir_i),
        .dis_sel_i (dis_sel_i),
        .oe_o      (oe_o)
    );

    assign arm_o       = arm_w;
    assign fault_lvl_o = lvl_w;
    assign fault_evt_o = fall_w;

    // R3
    fault_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_n_i |-> ((oe_o & dis_sel_i) == '0));
    // R2
    oe_needs_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_o & ~dir_i) == '0);
    // R1
    unprot_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((oe_o ^ dir_i) & ~dis_sel_i) == '0);
    // R2
    disarmed_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !arm_o |-> ((oe_o & dis_sel_i) == '0));

endmodule

// File: tb/fault_oe_gate_tb_top.sv
module fault_oe_gate_tb_top;
    localparam int N = 8;

    typedef struct {
        logic [N-1:0] oe;
        logic         arm;
        logic         lvl;
        logic         evt;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         fault_n = 1'b1;
    logic [N-1:0] dir = 8'hF0;
    logic [N-1:0] sel = 8'hCC;
    logic         wr = 1'b0;
    logic         wdata = 1'b0;
    logic [N-1:0] oe;
    logic         arm, lvl, evt;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    exp_t sb_q[$];
    event push_ev;

    always #10 clk = ~clk;

    fault_oe_gate #(.NUM_PINS(N), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .fault_n_i(fault_n),
        .dir_i(dir), .dis_sel_i(sel),
        .arm_wr_i(wr), .arm_wdata_i(wdata),
        .oe_o(oe), .arm_o(arm), .fault_lvl_o(lvl), .fault_evt_o(evt)
    );

    // monitor: pops expected items and compares them against the ports
    initial begin
        forever begin
            @(push_ev);
            #1;
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_checks++;
                if (oe !== e.oe || arm !== e.arm || lvl !== e.lvl || evt !== e.evt) begin
                    n_fail++;
                    $display("FAIL %s: got oe=%h arm=%b lvl=%b evt=%b, expected oe=%h arm=%b lvl=%b evt=%b",
                             e.tag, oe, arm, lvl, evt, e.oe, e.arm, e.lvl, e.evt);
                end
            end
        end
    end

    task automatic expect_now(input logic [N-1:0] e_oe, input logic e_arm,
                              input logic e_lvl, input logic e_evt, input string tag);
        exp_t e;
        e.oe = e_oe; e.arm = e_arm; e.lvl = e_lvl; e.evt = e_evt; e.tag = tag;
        sb_q.push_back(e);
        -> push_ev;
        #2;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic sw_write(input logic v);
        wr = 1'b1; wdata = v;
        tick();
        wr = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        tick(); tick();
        // R4: reset state, protected pins off (F0 & ~CC = 30)
        expect_now(8'h30, 1'b0, 1'b1, 1'b0, "R4 in reset");
        rst_n = 1'b1;
        tick();
        expect_now(8'h30, 1'b0, 1'b1, 1'b0, "R4 after reset");

        // R1: unprotected pins follow direction
        dir = 8'hA5; sel = 8'h00;
        expect_now(8'hA5, 1'b0, 1'b1, 1'b0, "R1 unprotected disarmed");

        // R5: arm by write 1
        dir = 8'hF0; sel = 8'hCC;
        sw_write(1'b1);
        expect_now(8'hF0, 1'b1, 1'b1, 1'b0, "R5 armed");
        // R2: protected pin gated by direction
        dir = 8'h3C;
        expect_now(8'h3C, 1'b1, 1'b1, 1'b0, "R2 armed follows dir");
        dir = 8'hF0;

        // R3: short low pulse between edges
        #3 fault_n = 1'b0;
        expect_now(8'h30, 1'b1, 1'b1, 1'b0, "R3 glitch kills protected");
        fault_n = 1'b1;
        expect_now(8'hF0, 1'b1, 1'b1, 1'b0, "R3 glitch released");
        tick(); tick(); tick();
        expect_now(8'hF0, 1'b1, 1'b1, 1'b0, "R8 glitch unseen by sync");

        // sustained fault
        fault_n = 1'b0;
        expect_now(8'h30, 1'b1, 1'b1, 1'b0, "R3 immediate shutdown");
        tick();
        expect_now(8'h30, 1'b1, 1'b1, 1'b0, "R8 one edge still high");
        tick();
        expect_now(8'h30, 1'b1, 1'b0, 1'b1, "R9 event on level drop");
        tick();
        expect_now(8'h30, 1'b0, 1'b0, 1'b0, "R6 arm cleared");
        // R1 with fault low
        sel = 8'h00; dir = 8'h0F;
        expect_now(8'h0F, 1'b0, 1'b0, 1'b0, "R1 fault no effect");
        sel = 8'hCC; dir = 8'hF0;

        // release: no auto-restore, no rising pulse
        fault_n = 1'b1;
        expect_now(8'h30, 1'b0, 1'b0, 1'b0, "R6 release no restore");
        tick();
        expect_now(8'h30, 1'b0, 1'b0, 1'b0, "R9 no pulse rising a");
        tick();
        expect_now(8'h30, 1'b0, 1'b1, 1'b0, "R9 no pulse rising b");
        tick(); tick();
        expect_now(8'h30, 1'b0, 1'b1, 1'b0, "R6 stays disarmed");

        // re-arm, then software clear
        sw_write(1'b1);
        expect_now(8'hF0, 1'b1, 1'b1, 1'b0, "R5 rearmed");
        sw_write(1'b0);
        expect_now(8'h30, 1'b0, 1'b1, 1'b0, "R5 software clear");

        // R7: set collides with active synchronized fault
        sw_write(1'b1);
        fault_n = 1'b0;
        tick(); tick();
        expect_now(8'h30, 1'b1, 1'b0, 1'b1, "R7 setup level low");
        wr = 1'b1; wdata = 1'b1;
        tick();
        expect_now(8'h30, 1'b0, 1'b0, 1'b0, "R7 clear wins");
        tick();
        wr = 1'b0;
        expect_now(8'h30, 1'b0, 1'b0, 1'b0, "R7 set ignored while low");
        fault_n = 1'b1;
        tick(); tick(); tick();
        sw_write(1'b1);
        expect_now(8'hF0, 1'b1, 1'b1, 1'b0, "R5 rearm after fault");

        tick();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule